// File: doc/BRIEF.md
# Shared-bus pseudo-SRAM access controller

This block sits on the host side of a 256K x 16 pseudo-static memory whose address and data travel over the same sixteen wires. A client issues one word request at a time through a valid/ready handshake. Each request carries an 18-bit word address, a write flag, 16 bits of write data and two byte enables. The controller turns the request into the memory's two-phase cycle. In the first phase it selects the chip and presents the low address half on the shared bus. It marks the address with an active-low address-valid pulse, and the two top address bits go out on dedicated pins. In the second phase it either releases the bus and enables the memory's output drivers, or it drives write data and pulses write enable.

The controller never drives the bus while the memory may still be driving it. After every access it deselects the chip and leaves the bus undriven for a recovery window before it starts the next access. Right after reset it keeps the chip deselected for a long power-up interval and does not accept any request. Every interval is a parameter counted in controller clock cycles, and each should be rounded up from the memory's nanosecond figure. Read data returns registered, with a valid strobe that lasts one cycle.

Top module: `psram_mux_ctrl`

## Requirements
- R1: While reset is high and for PWRUP_CYC clock edges after it falls, mem_cs_n is 1, mem_adq_oe is 0 and req_ready is 0. A request held valid during this time is not started. req_ready first reads 1 after exactly PWRUP_CYC rising edges after reset release.
- R2: An access starts with mem_cs_n low and mem_avd_n high for CSS_CYC cycles. Then mem_avd_n is low for AVD_CYC cycles. During that pulse mem_adq_oe is 1, mem_adq_o carries address bits 15:0 and mem_ahi carries address bits 17:16. mem_avd_n is low only while mem_cs_n is low.
- R3: After mem_avd_n rises, the address stays driven on the bus for HOLD_CYC cycles, with mem_oe_n and mem_we_n both high, before the data phase starts.
- R4: In a read, mem_adq_oe is 0 and mem_oe_n is low for RD_CYC cycles. The bus is sampled at the clock edge that ends the last of these cycles, and that value appears on rsp_rdata with rsp_valid high in the following cycle.
- R5: In a write, mem_adq_o carries the write data with mem_adq_oe at 1 while mem_we_n is low for WR_CYC cycles. mem_we_n and mem_cs_n rise on the same edge, and that edge ends the write.
- R6: req_be bit 0 drives mem_lb_n low (bus bits 7:0) and req_be bit 1 drives mem_ub_n low (bits 15:8), during the data phase only. A write changes only the enabled bytes. A read returns the bytes it did not enable as zero.
- R7: Between accesses mem_cs_n is high and mem_adq_oe is 0 for at least HZ_CYC cycles.
- R8: req_ready is 0 throughout an access. Each request is accepted on exactly one rising edge where req_valid and req_ready are both 1, and starts exactly one address pulse.
- R9: mem_oe_n and mem_we_n are never low together, and the bus is never driven while mem_oe_n is low.
- R10: rsp_valid is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 18 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled bytes zero |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_avd_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ahi | output | 2 | Address bits 17:16 |
| mem_adq_o | output | 16 | Shared bus, outbound value |
| mem_adq_oe | output | 1 | Shared bus drive enable |
| mem_adq_i | input | 16 | Shared bus, inbound value |

## Verification
Two things can land on the same cycle. A read response can come out while the next request is already waiting at the handshake, and the end of a recovery window can meet a new acceptance. The bench provokes both by keeping req_valid high back to back across mixed reads and writes, so a new request is always waiting when rsp_valid pulses and when recovery ends. It then judges the pin traffic against a cycle-counting memory model: phase lengths, address hold, recovery length and the number of address pulses per accepted request. Returned data is compared against a separate reference image built from the requests alone.

// File: rtl/psram_ctl_pkg.sv
`timescale 1ns/1ps
package psram_ctl_pkg;

  typedef enum logic [2:0] {
    S_PWRUP,
    S_IDLE,
    S_CSS,
    S_ALAT,
    S_AHLD,
    S_RD,
    S_WR,
    S_REC
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_cyc_timer.sv
`timescale 1ns/1ps
module psram_cyc_timer #(
  parameter int           CW      = 8,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= RST_VAL;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/psram_read_capture.sv
`timescale 1ns/1ps
module psram_read_capture #(
  parameter int DATA_W = 16,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] masked;

  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign masked[b*8 +: 8] = be[b] ? din[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) rsp_rdata <= masked;
    end
  end

  // R10: the read strobe is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/psram_seq.sv
`timescale 1ns/1ps
module psram_seq
  import psram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int BE_W      = DATA_W / 8,
  parameter int HI_W      = ADDR_W - DATA_W,
  parameter int CW        = 16,
  parameter int PWRUP_CYC = 25000,
  parameter int CSS_CYC   = 1,
  parameter int AVD_CYC   = 2,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 9,
  parameter int WR_CYC    = 6,
  parameter int HZ_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [CW-1:0]     tmr_val,
  output logic              cap_fire,
  output logic [BE_W-1:0]   cap_be,
  output logic              mem_cs_n,
  output logic              mem_avd_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [HI_W-1:0]   mem_ahi,
  output logic [DATA_W-1:0] mem_adq_o,
  output logic              mem_adq_oe
);

  phase_e st, nxt;
  logic   take;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [BE_W-1:0]   be_q, be_d;
  logic              wr_q, wr_d;

  function automatic int phase_len(input phase_e p);
    case (p)
      S_PWRUP: return PWRUP_CYC;
      S_CSS:   return CSS_CYC;
      S_ALAT:  return AVD_CYC;
      S_AHLD:  return HOLD_CYC;
      S_RD:    return RD_CYC;
      S_WR:    return WR_CYC;
      S_REC:   return HZ_CYC;
      default: return 1;
    endcase
  endfunction

  assign take = (st == S_IDLE) && req_valid;

  always_comb begin
    nxt = st;
    case (st)
      S_PWRUP: if (tmr_done) nxt = S_IDLE;
      S_IDLE:  if (take)     nxt = S_CSS;
      S_CSS:   if (tmr_done) nxt = S_ALAT;
      S_ALAT:  if (tmr_done) nxt = S_AHLD;
      S_AHLD:  if (tmr_done) nxt = wr_q ? S_WR : S_RD;
      S_RD:    if (tmr_done) nxt = S_REC;
      S_WR:    if (tmr_done) nxt = S_REC;
      S_REC:   if (tmr_done) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign tmr_load = (nxt != st);
  assign tmr_val  = CW'(phase_len(nxt) - 1);
  assign cap_fire = (st == S_RD) && tmr_done;
  assign cap_be   = be_q;

  assign addr_d  = take ? req_addr  : addr_q;
  assign wdata_d = take ? req_wdata : wdata_q;
  assign be_d    = take ? req_be    : be_q;
  assign wr_d    = take ? req_write : wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_PWRUP;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
    end else begin
      st      <= nxt;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      be_q    <= be_d;
      wr_q    <= wr_d;
    end
  end

  logic n_sel, n_adr, n_dat;
  assign n_adr = (nxt == S_CSS) || (nxt == S_ALAT) || (nxt == S_AHLD);
  assign n_dat = (nxt == S_RD)  || (nxt == S_WR);
  assign n_sel = n_adr || n_dat;

  // Pins are registered from the next phase so they change cleanly on an edge
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cs_n   <= 1'b1;
      mem_avd_n  <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_ahi    <= '0;
      mem_adq_o  <= '0;
      mem_adq_oe <= 1'b0;
      req_ready  <= 1'b0;
    end else begin
      mem_cs_n   <= !n_sel;
      mem_avd_n  <= !(nxt == S_ALAT);
      mem_oe_n   <= !(nxt == S_RD);
      mem_we_n   <= !(nxt == S_WR);
      mem_ub_n   <= !(n_dat && be_d[BE_W-1]);
      mem_lb_n   <= !(n_dat && be_d[0]);
      mem_ahi    <= addr_d[ADDR_W-1:DATA_W];
      mem_adq_o  <= (nxt == S_WR) ? wdata_d :
                    n_adr         ? addr_d[DATA_W-1:0] : '0;
      mem_adq_oe <= n_adr || (nxt == S_WR);
      req_ready  <= (nxt == S_IDLE);
    end
  end

  // R9: read and write enables are mutually exclusive
  a_r9_oe_we_excl: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));
  // R9: no drive while the memory outputs are enabled
  a_r9_no_contention: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_adq_oe);
  // R2: address strobe only inside a selected cycle
  a_r2_avd_in_cs: assert property (@(posedge clk) disable iff (rst)
    !mem_avd_n |-> !mem_cs_n);
  // R3: address phase keeps the bus driven
  a_r3_addr_driven: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && mem_oe_n && mem_we_n) |-> mem_adq_oe);
  // R6: byte strobes only inside a selected cycle
  a_r6_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!mem_ub_n || !mem_lb_n) |-> !mem_cs_n);
  // R5: write enable and chip select release together
  a_r5_write_end: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_cs_n);
  // R7: deselected bus is never driven
  a_r7_rec_undriven: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n |-> !mem_adq_oe);
  // R8: ready only while the chip is deselected
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_cs_n);

endmodule

// File: rtl/psram_mux_ctrl.sv
`timescale 1ns/1ps
module psram_mux_ctrl
  import psram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int PWRUP_CYC = 25000,
  parameter int CSS_CYC   = 1,
  parameter int AVD_CYC   = 2,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 9,
  parameter int WR_CYC    = 6,
  parameter int HZ_CYC    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W/8-1:0]  req_be,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 mem_cs_n,
  output logic                 mem_avd_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic                 mem_ub_n,
  output logic                 mem_lb_n,
  output logic [ADDR_W-DATA_W-1:0] mem_ahi,
  output logic [DATA_W-1:0]    mem_adq_o,
  output logic                 mem_adq_oe,
  input  logic [DATA_W-1:0]    mem_adq_i
);

  localparam int BE_W = DATA_W / 8;
  localparam int HI_W = ADDR_W - DATA_W;
  localparam int MAXC = max2(max2(max2(PWRUP_CYC, CSS_CYC), max2(AVD_CYC, HOLD_CYC)),
                             max2(max2(RD_CYC, WR_CYC), HZ_CYC));
  localparam int CW   = $clog2(MAXC + 1);

  logic          tmr_done, tmr_load, cap_fire;
  logic [CW-1:0] tmr_val;
  logic [BE_W-1:0] cap_be;

  psram_cyc_timer #(
    .CW      (CW),
    .RST_VAL (CW'(PWRUP_CYC - 1))
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  psram_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BE_W      (BE_W),
    .HI_W      (HI_W),
    .CW        (CW),
    .PWRUP_CYC (PWRUP_CYC),
    .CSS_CYC   (CSS_CYC),
    .AVD_CYC   (AVD_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .RD_CYC    (RD_CYC),
    .WR_CYC    (WR_CYC),
    .HZ_CYC    (HZ_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .cap_fire   (cap_fire),
    .cap_be     (cap_be),
    .mem_cs_n   (mem_cs_n),
    .mem_avd_n  (mem_avd_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_ub_n   (mem_ub_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ahi    (mem_ahi),
    .mem_adq_o  (mem_adq_o),
    .mem_adq_oe (mem_adq_oe)
  );

  psram_read_capture #(
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .fire      (cap_fire),
    .be        (cap_be),
    .din       (mem_adq_i),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R1: the chip stays deselected while the controller is not ready and idle
  a_r1_no_access_unready: assert property (@(posedge clk) disable iff (rst)
    (mem_cs_n && !req_ready && !rsp_valid && $stable(mem_cs_n)) |-> !mem_adq_oe);

endmodule

// File: tb/psram_mux_ctrl_test.sv
`timescale 1ns/1ps
module psram_mux_ctrl_test;

  localparam int PWRUP = 20;
  localparam int CSS   = 1;
  localparam int AVD   = 2;
  localparam int HOLD  = 1;
  localparam int RD    = 3;
  localparam int WR    = 2;
  localparam int HZ    = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_avd_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  logic [1:0]  mem_ahi;
  logic [15:0] mem_adq_o;
  logic        mem_adq_oe;
  logic [15:0] mem_adq_i = '0;

  always #4 clk = ~clk;

  psram_mux_ctrl #(
    .PWRUP_CYC (PWRUP), .CSS_CYC (CSS), .AVD_CYC (AVD), .HOLD_CYC (HOLD),
    .RD_CYC (RD), .WR_CYC (WR), .HZ_CYC (HZ)
  ) uut (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .req_write (req_write), .req_wdata (req_wdata), .req_be (req_be),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .mem_cs_n (mem_cs_n), .mem_avd_n (mem_avd_n), .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n), .mem_ub_n (mem_ub_n), .mem_lb_n (mem_lb_n),
    .mem_ahi (mem_ahi), .mem_adq_o (mem_adq_o), .mem_adq_oe (mem_adq_oe),
    .mem_adq_i (mem_adq_i)
  );

  int n_run = 0;
  int n_fail = 0;
  int n_acc = 0;
  int n_avd = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference image built from requests; pin image built from the bus
  logic [15:0] ref_m [int];
  logic [15:0] pin_m [int];
  logic [15:0] exp_q [$];

  function automatic logic [15:0] ref_get(input int a);
    return ref_m.exists(a) ? ref_m[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] pin_get(input int a);
    return pin_m.exists(a) ? pin_m[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] be_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // pin-level memory model and protocol monitor
  logic        p_cs = 1, p_avd = 1, p_oe = 1, p_we = 1, p_rsp = 0;
  int          cs_run = 0, cs_hi_run = 0, avd_run = 0, hold_run = 0, oe_cnt = 0, we_run = 0;
  bit          hold_on = 0;
  logic [17:0] a_lat = '0, m_addr = '0;
  logic [15:0] w_data = '0;
  logic        w_ub = 1, w_lb = 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_cs_n && p_cs) begin
        chk(cs_hi_run >= HZ, "R7 recovery before select", cs_hi_run, HZ);
        cs_hi_run = 0;
      end
      if (mem_cs_n) begin
        cs_hi_run++;
        if (mem_adq_oe) chk(1'b0, "R7 bus driven while deselected", 1, 0);
      end
      if (!mem_avd_n && p_avd) begin
        n_avd++;
        chk(cs_run == CSS, "R2 select setup", cs_run, CSS);
      end
      if (!mem_avd_n) begin
        avd_run++;
        a_lat = {mem_ahi, mem_adq_o};
        if (!mem_adq_oe) chk(1'b0, "R2 address not driven", 0, 1);
      end
      if (mem_avd_n && !p_avd) begin
        chk(avd_run == AVD, "R2 strobe width", avd_run, AVD);
        m_addr = a_lat;
        avd_run = 0;
        hold_run = 0;
        hold_on = 1;
      end
      if (hold_on && mem_avd_n && mem_oe_n && mem_we_n && !mem_cs_n) begin
        hold_run++;
        if (!(mem_adq_oe && {mem_ahi, mem_adq_o} == m_addr))
          chk(1'b0, "R3 address held", {mem_ahi, mem_adq_o}, m_addr);
      end
      if ((!mem_oe_n && p_oe) || (!mem_we_n && p_we)) begin
        chk(hold_run == HOLD, "R3 hold length", hold_run, HOLD);
        hold_on = 0;
      end
      if (!mem_cs_n) cs_run++; else cs_run = 0;
      if (!mem_oe_n) begin
        oe_cnt++;
        if (mem_adq_oe) chk(1'b0, "R9 contention", 1, 0);
        if (!mem_we_n) chk(1'b0, "R9 oe and we both low", 1, 0);
      end
      if (mem_oe_n && !p_oe) begin
        chk(oe_cnt == RD, "R4 output enable length", oe_cnt, RD);
        oe_cnt = 0;
      end
      if (!mem_we_n) begin
        we_run++;
        w_data = mem_adq_o;
        w_ub = mem_ub_n;
        w_lb = mem_lb_n;
        if (!mem_adq_oe) chk(1'b0, "R5 write data not driven", 0, 1);
      end
      if (mem_we_n && !p_we) begin
        chk(we_run == WR, "R5 write pulse length", we_run, WR);
        chk(mem_cs_n, "R5 write ends with deselect", mem_cs_n, 1);
        begin
          logic [15:0] cur;
          cur = pin_get(int'(m_addr));
          if (!w_lb) cur[7:0] = w_data[7:0];
          if (!w_ub) cur[15:8] = w_data[15:8];
          pin_m[int'(m_addr)] = cur;
        end
        we_run = 0;
      end
      if (req_ready && !mem_cs_n) chk(1'b0, "R8 ready during access", 1, 0);
      if (rsp_valid) begin
        logic [15:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
        chk(rsp_rdata === e, "R4 R6 read data", rsp_rdata, e);
      end
      if (rsp_valid && p_rsp) chk(1'b0, "R10 strobe longer than one cycle", 1, 0);
      begin
        logic [15:0] d;
        d = pin_get(int'(m_addr));
        if (!mem_oe_n && oe_cnt >= RD)
          mem_adq_i = {mem_ub_n ? 8'hA5 : d[15:8], mem_lb_n ? 8'h5A : d[7:0]};
        else
          mem_adq_i = ~d;
      end
      p_cs = mem_cs_n; p_avd = mem_avd_n; p_oe = mem_oe_n; p_we = mem_we_n; p_rsp = rsp_valid;
    end
  end

  // issue one request; called at a negedge, returns at the negedge after acceptance
  task automatic do_req(input logic [17:0] a, input bit w, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    n_acc++;
    if (w) ref_m[int'(a)] = (ref_get(int'(a)) & ~be_mask(be)) | (d & be_mask(be));
    else   exp_q.push_back(ref_get(int'(a)) & be_mask(be));
  endtask

  task automatic go_idle();
    req_valid = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (HZ + 4) @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input logic [17:0] a);
    return a[15:0] ^ {a[17:16], 14'h0} ^ 16'hC3A5;
  endfunction

  logic [17:0] alist [8] = '{18'h00000, 18'h00001, 18'h0FFFF, 18'h10000,
                             18'h20000, 18'h30000, 18'h2ABCD, 18'h3FFFF};

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_cs_n == 1'b1, "R1 reset chip select", mem_cs_n, 1);
    chk(req_ready == 1'b0, "R1 reset ready", req_ready, 0);
    chk(mem_adq_oe == 1'b0, "R1 reset bus drive", mem_adq_oe, 0);
    chk(rsp_valid == 1'b0, "R1 reset response", rsp_valid, 0);
    rst = 1'b0;
    // R1: a request held through power-up is not started
    req_valid = 1'b1; req_addr = 18'h00000; req_write = 1'b1; req_wdata = 16'h1234; req_be = 2'b11;
    n = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (req_ready) break;
      if (!mem_cs_n || mem_adq_oe) chk(1'b0, "R1 access during power-up", mem_cs_n, 1);
    end
    chk(n == PWRUP, "R1 power-up length", n, PWRUP);
    do_req(18'h00000, 1'b1, 16'h1234, 2'b11);

    // full-word writes, reads under every byte-enable pattern, back to back (R2 R4 R6 R8)
    foreach (alist[i]) begin
      do_req(alist[i], 1'b1, pat(alist[i]), 2'b11);
      for (int be = 0; be < 4; be++) do_req(alist[i], 1'b0, 16'h0, be[1:0]);
    end
    // partial writes then full reads (R5 R6)
    foreach (alist[i]) begin
      for (int be = 1; be < 4; be++) begin
        do_req(alist[i], 1'b1, ~pat(alist[i]) + 16'(be * 16'h0101), be[1:0]);
        do_req(alist[i], 1'b0, 16'h0, 2'b11);
      end
    end
    // zero byte enables: write changes nothing, read returns zero (R6)
    do_req(18'h2ABCD, 1'b1, 16'hFFFF, 2'b00);
    do_req(18'h2ABCD, 1'b0, 16'h0, 2'b00);
    do_req(18'h2ABCD, 1'b0, 16'h0, 2'b11);
    go_idle();
    // isolated accesses with idle gaps (R7)
    for (int k = 0; k < 4; k++) begin
      do_req(alist[k], 1'b0, 16'h0, 2'b11);
      go_idle();
    end
    // final sweep proves upper address bits select distinct words (R2)
    foreach (alist[i]) do_req(alist[i], 1'b0, 16'h0, 2'b11);
    go_idle();
    chk(n_avd == n_acc, "R8 one address pulse per request", n_avd, n_acc);
    chk(exp_q.size() == 0, "R4 all responses returned", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired: R8 actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule